// File: doc/BRIEF.md
# Nine-Bit Serial Panel Command Writer

This block drives a display controller's configuration port over a three-wire serial link: a serial clock, an active-high select and one data line. A client hands it one request that holds a command byte, a parameter word of up to four bytes and a count of how many of those bytes to send. The block sends the command and then the selected parameter bytes. Each byte goes out as a nine-bit word. The first bit tells the panel whether the byte is a command or a parameter. When the link has gone quiet again, the block pulses `done`.

The request side is a valid/ready port. `req_ready` is high only while the writer is idle. A request is taken on the clock edge where `req_valid` and `req_ready` are both high. While the writer is busy it holds `req_ready` low, so the client keeps its request pending. The fields are captured at acceptance and are not looked at after that. The serial clock runs at the system clock divided by `2*HALF_CYCLES`.

Top module: `panel_cmd_writer`

## Requirements
- R1: After reset and between transactions the link rests with `pnl_sclk`=1, `pnl_cs`=0 and `pnl_sdo`=0, with `req_ready`=1, `busy`=0 and `done`=0.
- R2: A request is accepted only on an edge where `req_valid` and `req_ready` are both 1. From the next cycle `req_ready` is 0 and `busy` is 1 until `done` has pulsed. A request held valid during that time is not taken.
- R3: Every byte is sent as a 9-bit word. The first bit is a data/command flag: 0 for the command byte, 1 for a parameter byte. The 8 data bits follow, most significant first.
- R4: The command word always comes first. With count N it is followed by N parameter words, taken from `req_param` bits [8N-1:8N-8] first down to bits [7:0] last.
- R5: A count of 0 sends the command word alone, which is nine clock pulses.
- R6: `pnl_sdo` changes only while `pnl_sclk` is low and is stable through each high phase; the panel samples on the rising edge. Every low phase and every high phase lasts exactly `HALF_CYCLES` system clocks.
- R7: `pnl_cs` rises in the cycle after acceptance, together with the first falling `pnl_sclk`. It stays high for 18*`HALF_CYCLES`*(N+1) cycles, which holds exactly 9*(N+1) rising clock edges. It falls while `pnl_sclk` is high.
- R8: After `pnl_cs` falls the link stays idle for 2*`HALF_CYCLES` cycles. `done` is then high for exactly one cycle, and `req_ready` returns in the following cycle.
- R9: Parameter bits at or above position 8N are ignored and never appear on the link.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request is presented |
| req_ready | output | 1 | Writer is idle and will take a request |
| req_cmd | input | 8 | Command byte |
| req_param | input | 8*MAX_PARAMS | Parameter bytes; the low 8N bits are used |
| req_count | input | $clog2(MAX_PARAMS+1) | Number of parameter bytes N |
| busy | output | 1 | Transaction in progress, from acceptance through `done` |
| done | output | 1 | One-cycle pulse when a transaction is over |
| pnl_sclk | output | 1 | Serial clock, idle high |
| pnl_cs | output | 1 | Active-high select |
| pnl_sdo | output | 1 | Serial data out |

## Verification
The checker assumes two things about the client. `req_count` never exceeds `MAX_PARAMS` while `req_valid` is high. Reset is applied synchronously before the first request. Under those assumptions it checks the idle levels, the handshake exclusion, data stability during high clock phases, and the select falling only while the clock is high. The stimulus draws every count from the range 0 to `MAX_PARAMS` and fills the unused upper parameter bits with random values. It also holds one request valid through a whole transaction, so the back-pressure rule is exercised.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int WORD_BITS = 9;
  localparam int BYTE_BITS = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_GAP,
    ST_DONE
  } pw_state_e;
endpackage

// File: rtl/pw_half_timer.sv
// Free-running phase timer: tick every HALF_CYCLES clocks, restartable.
module pw_half_timer #(
  parameter int HALF_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) cnt <= '0;
    else if (tick)         cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pw_param_pick.sv
// Selects the parameter byte for word index idx (1..count): byte count-idx.
module pw_param_pick #(
  parameter int MAX_PARAMS = 4,
  parameter int CNT_W      = 3
) (
  input  logic [8*MAX_PARAMS-1:0] param,
  input  logic [CNT_W-1:0]        count,
  input  logic [CNT_W-1:0]        idx,
  output logic [7:0]              byte_o
);
  logic [CNT_W-1:0] sel;
  assign sel = count - idx;

  always_comb begin
    byte_o = '0;
    for (int i = 0; i < MAX_PARAMS; i++) begin
      if (sel == CNT_W'(i)) byte_o = param[8*i +: 8];
    end
  end
endmodule

// File: rtl/pw_shifter.sv
// Word shift register; the MSB drives the data line.
module pw_shifter #(
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_word,
  input  logic             shift,
  input  logic             clear,
  output logic             msb
);
  logic [WIDTH-1:0] sh;

  assign msb = sh[WIDTH-1];

  always_ff @(posedge clk) begin
    if (!rst_n || clear) sh <= '0;
    else if (load)       sh <= load_word;
    else if (shift)      sh <= {sh[WIDTH-2:0], 1'b0};
  end
endmodule

// File: rtl/panel_cmd_writer.sv
module panel_cmd_writer
  import pw_pkg::*;
#(
  parameter int HALF_CYCLES = 4,
  parameter int MAX_PARAMS  = 4,
  localparam int PARAM_W    = 8 * MAX_PARAMS,
  localparam int CNT_W      = $clog2(MAX_PARAMS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [7:0]         req_cmd,
  input  logic [PARAM_W-1:0] req_param,
  input  logic [CNT_W-1:0]   req_count,
  output logic               busy,
  output logic               done,
  output logic               pnl_sclk,
  output logic               pnl_cs,
  output logic               pnl_sdo
);
  localparam int BIT_W = $clog2(WORD_BITS);
  localparam logic [BIT_W-1:0] FIRST_BIT = BIT_W'(WORD_BITS - 1);

  pw_state_e          state;
  logic [PARAM_W-1:0] param_q;
  logic [CNT_W-1:0]   count_q;
  logic [CNT_W-1:0]   word_idx;
  logic [CNT_W-1:0]   next_idx;
  logic [BIT_W-1:0]   bits_left;
  logic               gap_second;
  logic               sclk_q;
  logic               cs_q;
  logic               tick;
  logic               accept;
  logic               word_end;
  logic               last_word;
  logic               sh_load;
  logic               sh_shift;
  logic               sh_clear;
  logic [7:0]         pick_byte;
  logic [WORD_BITS-1:0] load_word;

  assign accept    = req_valid && (state == ST_IDLE);
  assign next_idx  = word_idx + 1'b1;
  assign word_end  = (state == ST_HIGH) && tick && (bits_left == '0);
  assign last_word = (word_idx == count_q);
  assign sh_load   = accept || (word_end && !last_word);
  assign sh_shift  = (state == ST_HIGH) && tick && (bits_left != '0);
  assign sh_clear  = word_end && last_word;
  assign load_word = accept ? {1'b0, req_cmd} : {1'b1, pick_byte};

  pw_half_timer #(.HALF_CYCLES(HALF_CYCLES)) i_timer (
    .clk(clk), .rst_n(rst_n), .restart(accept), .tick(tick)
  );

  pw_param_pick #(.MAX_PARAMS(MAX_PARAMS), .CNT_W(CNT_W)) i_pick (
    .param(param_q), .count(count_q), .idx(next_idx), .byte_o(pick_byte)
  );

  pw_shifter #(.WIDTH(WORD_BITS)) i_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .load_word(load_word),
    .shift(sh_shift), .clear(sh_clear), .msb(pnl_sdo)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      param_q    <= '0;
      count_q    <= '0;
      word_idx   <= '0;
      bits_left  <= '0;
      gap_second <= 1'b0;
      sclk_q     <= 1'b1;
      cs_q       <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state     <= ST_LOW;
          param_q   <= req_param;
          count_q   <= req_count;
          word_idx  <= '0;
          bits_left <= FIRST_BIT;
          sclk_q    <= 1'b0;
          cs_q      <= 1'b1;
        end
        ST_LOW: if (tick) begin
          state  <= ST_HIGH;
          sclk_q <= 1'b1;
        end
        ST_HIGH: if (tick) begin
          if (bits_left != '0) begin
            bits_left <= bits_left - 1'b1;
            state     <= ST_LOW;
            sclk_q    <= 1'b0;
          end else if (!last_word) begin
            word_idx  <= next_idx;
            bits_left <= FIRST_BIT;
            state     <= ST_LOW;
            sclk_q    <= 1'b0;
          end else begin
            state      <= ST_GAP;
            cs_q       <= 1'b0;
            gap_second <= 1'b0;
          end
        end
        ST_GAP: if (tick) begin
          if (gap_second) state <= ST_DONE;
          else            gap_second <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_DONE);
  assign pnl_sclk  = sclk_q;
  assign pnl_cs    = cs_q;
endmodule

// File: rtl/pw_checker.sv
module pw_checker #(
  parameter int MAX_PARAMS = 4,
  parameter int CNT_W      = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [CNT_W-1:0] req_count,
  input logic             busy,
  input logic             done,
  input logic             pnl_sclk,
  input logic             pnl_cs,
  input logic             pnl_sdo
);
  AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (pnl_sclk && !pnl_cs && !pnl_sdo && !busy && !done)); // R1

  AST_READY_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready); // R2

  AST_ACCEPT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (pnl_cs && !pnl_sclk && busy)); // R7

  AST_SDO_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (pnl_cs && $past(pnl_cs) && pnl_sclk && $past(pnl_sclk)) |-> $stable(pnl_sdo)); // R6

  AST_CS_FALL_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pnl_cs) |-> (pnl_sclk && $past(pnl_sclk))); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready)); // R8

  AST_DONE_LINK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!pnl_cs && pnl_sclk && busy)); // R8

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_count <= CNT_W'(MAX_PARAMS))); // R4
endmodule

bind panel_cmd_writer pw_checker #(.MAX_PARAMS(MAX_PARAMS), .CNT_W(CNT_W)) i_pw_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_count(req_count), .busy(busy), .done(done),
  .pnl_sclk(pnl_sclk), .pnl_cs(pnl_cs), .pnl_sdo(pnl_sdo)
);

// File: tb/test_panel_cmd_writer.sv
`timescale 1ns/1ps
module test_panel_cmd_writer;
  localparam int HALF = 3;
  localparam int MAXP = 4;
  localparam int PW   = 8 * MAXP;
  localparam int CW   = $clog2(MAXP + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [7:0] req_cmd = '0;
  logic [PW-1:0] req_param = '0;
  logic [CW-1:0] req_count = '0;
  logic busy, done, pnl_sclk, pnl_cs, pnl_sdo;

  always #10 clk = ~clk;

  panel_cmd_writer #(.HALF_CYCLES(HALF), .MAX_PARAMS(MAXP)) i_panel_cmd_writer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_param(req_param), .req_count(req_count),
    .busy(busy), .done(done), .pnl_sclk(pnl_sclk), .pnl_cs(pnl_cs), .pnl_sdo(pnl_sdo)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Serial decoder: sample on rising serial clock while selected.
  logic [8:0] rx_words [0:63];
  int rx_n = 0;
  int rx_bits = 0;
  int rise_n = 0;
  logic [8:0] rx_sh = '0;
  always @(posedge pnl_sclk) begin
    if (pnl_cs) begin
      rx_sh = {rx_sh[7:0], pnl_sdo};
      rx_bits++;
      rise_n++;
      if (rx_bits == 9) begin
        rx_words[rx_n % 64] = rx_sh;
        rx_n++;
        rx_bits = 0;
      end
    end
  end

  // Phase-length and data-stability monitor (R6).
  int mon_err = 0;
  int lowrun = 0;
  int highrun = 0;
  logic prev_sclk = 1'b1, prev_cs = 1'b0, prev_sdo = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pnl_sclk && !prev_sclk && pnl_cs && lowrun != HALF) mon_err++;
      if (!pnl_sclk && prev_sclk && prev_cs && highrun != HALF) mon_err++;
      if (pnl_cs && prev_cs && pnl_sclk && prev_sclk && pnl_sdo != prev_sdo) mon_err++;
    end
    if (!pnl_sclk) lowrun++; else lowrun = 0;
    if (pnl_sclk) highrun++; else highrun = 0;
    prev_sclk = pnl_sclk;
    prev_cs   = pnl_cs;
    prev_sdo  = pnl_sdo;
  end

  function automatic logic [8:0] exp_word(input logic [7:0] cmd, input logic [PW-1:0] par,
                                          input int n, input int k);
    if (k == 0) return {1'b0, cmd};
    return {1'b1, par[8*(n-k) +: 8]};
  endfunction

  task automatic check_idle(input string tag);
    chk({tag, " sclk"}, 32'(pnl_sclk), 1);
    chk({tag, " cs"}, 32'(pnl_cs), 0);
    chk({tag, " sdo"}, 32'(pnl_sdo), 0);
    chk({tag, " ready"}, 32'(req_ready), 1);
    chk({tag, " busy"}, 32'(busy), 0);
    chk({tag, " done"}, 32'(done), 0);
  endtask

  task automatic send(input logic [7:0] cmd, input logic [PW-1:0] par, input int n,
                      input bit hold);
    int w0, r0, e0, cs_cyc, gap_cyc, ready_seen;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    w0 = rx_n; r0 = rise_n; e0 = mon_err;
    req_valid = 1'b1; req_cmd = cmd; req_param = par; req_count = CW'(n);
    @(negedge clk);
    req_valid = hold;
    if (!hold) begin
      req_cmd = 8'($urandom); req_param = PW'($urandom); // captured fields no longer used
    end
    chk("R2 ready low after accept", 32'(req_ready), 0);
    chk("R2 busy after accept", 32'(busy), 1);
    chk("R7 cs rises with sclk low", {30'd0, pnl_cs, pnl_sclk}, 32'b10);
    cs_cyc = 0; ready_seen = 0;
    while (pnl_cs) begin
      cs_cyc++;
      if (req_ready || done) ready_seen++;
      @(negedge clk);
    end
    chk("R7 cs high cycles", 32'(cs_cyc), 32'(18 * HALF * (n + 1)));
    chk("R2 no ready while busy", 32'(ready_seen), 0);
    gap_cyc = 0;
    while (!done) begin
      gap_cyc++;
      if (req_ready) ready_seen++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk("R8 idle gap cycles", 32'(gap_cyc), 32'(2 * HALF));
    chk("R8 busy during done", 32'(busy), 1);
    @(negedge clk);
    check_idle("R8 after done");
    chk("R5 word count", 32'(rx_n - w0), 32'(n + 1));
    chk("R7 rising edges", 32'(rise_n - r0), 32'(9 * (n + 1)));
    chk("R6 phase monitor errors", 32'(mon_err - e0), 0);
    for (int k = 0; k <= n && k < rx_n - w0; k++)
      chk(k == 0 ? "R3 command word" : "R4 R9 parameter word",
          32'(rx_words[(w0 + k) % 64]), 32'(exp_word(cmd, par, n, k)));
    if (hold) begin
      @(negedge clk);
      chk("R2 held request not taken", 32'(pnl_cs), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R8 watchdog: actual timeout expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 reset");
    // Directed corner cases
    send(8'h11, '0, 0, 1'b0);                   // R5 command only
    send(8'h29, 32'hFFFF_FFFF, 0, 1'b0);        // R5 R9 params ignored
    send(8'hC3, 32'h0000_3232, 2, 1'b0);        // R4 two bytes
    send(8'hD0, 32'h0000_C003, 2, 1'b0);        // R4 byte order
    send(8'hBA, 32'hDEAD_BE11, 1, 1'b0);        // R9 upper bits ignored
    send(8'hA5, 32'hA1B2_C3D4, 4, 1'b0);        // R4 full width
    send(8'hEC, 32'h0002_A4FF, 3, 1'b1);        // R2 request held while busy
    send(8'h00, 32'h0000_0000, 0, 1'b0);        // R3 all-zero command
    // Constrained random
    for (int t = 0; t < 24; t++)
      send(8'($urandom), PW'($urandom), int'($urandom_range(0, MAXP)), 1'b0);
    check_idle("R1 final");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule